// File: doc/BRIEF.md
# Pipelined Circular-Rotation CORDIC

This block rotates a two-component vector by a signed angle and returns the rotated components together with the angle still left unresolved. It is fully pipelined. Every stage applies one fixed micro-rotation built only from add/subtract operations and hard-wired arithmetic shifts. A register separates each stage from the next. A new operand can enter on every clock, and a result leaves on every clock once the pipeline has filled.

Its main use is as the numerically controlled oscillator and phase-detection element of a complex digital phase-locked loop. To get cosine and sine of an angle, start the vector on the real axis at the pre-shrunk length A·K, where K is the combined gain of all stages. The outputs are then A·cos and A·sin. To rotate an arbitrary vector, start it anywhere; its length grows by the stage gain 1/K. Each adder saturates to the sign its operands share when the true result does not fit. It never wraps around.

Top module: `cordic_rot_pipe`

## Requirements
- R1: A synchronous active-low reset clears every stage register. `out_vld` is low from the first rising edge with `rst_n` low until new operands have travelled through the pipeline. Operands in flight when reset is applied are discarded.
- R2: A result appears exactly NUM_STAGES (16) rising edges after its operand was sampled with `in_vld` high. Results come out in issue order.
- R3: With start vector (round(K·65536), 0), `out_x` equals 65536·cos(θ) within 8 LSB. K is the product over i = 0..15 of 1/sqrt(1+2^-2i).
- R4: With the same start vector, `out_y` equals 65536·sin(θ) within 8 LSB.
- R5: The angle endpoints −π/2 (code −65536) and +π/2 (code +65536) meet R3 and R4, giving about (0, ∓65536) and (0, +65536).
- R6: The angle is an 18-bit two's-complement value in which 2^17 stands for π. For any input angle in [−65536, +65536], the residual `out_ang` is within ±8 codes of zero.
- R7: An arbitrary start vector (x, y) comes out as G·(x·cosθ − y·sinθ, x·sinθ + y·cosθ) within 8 LSB, where G = 1/K.
- R8: When an x or y adder's true result falls outside the 18-bit signed range, that adder clamps to the extreme value of its operands' sign. For the start vector (120000, 0) at angle 0, `out_x` stays positive and at least 90000.
- R9: Operands issued on consecutive clocks, or with arbitrary gaps between them, produce exactly one result each, with the same spacing between results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_vld | input | 1 | Operand strobe for the current cycle |
| in_x | input | 18 | Start vector real part, signed |
| in_y | input | 18 | Start vector imaginary part, signed |
| in_ang | input | 18 | Rotation angle, signed, 2^17 = π |
| out_vld | output | 1 | Result strobe |
| out_x | output | 18 | Rotated real part, signed |
| out_y | output | 18 | Rotated imaginary part, signed |
| out_ang | output | 18 | Residual angle, signed |

## Verification
Every result is due exactly 16 rising edges after the edge that sampled its operand. The bench drives inputs on the falling edge. It stamps each expected item with the cycle count at issue and queues it. The monitor samples on the falling edge and pops one item whenever `out_vld` is high. It checks that the cycle difference is exactly 16 and compares the data against real-number references within the stated tolerance. After a reset in mid-stream, the monitor expects no strobe at all, and at the end the queue must be empty. That way a lost, extra or late result is caught as well as a wrong value.

// File: rtl/cordic_rot_pkg.sv
// cordic_rot_pkg
// Shared constants for the rotation pipeline. The micro-rotation angle
// table is held at an 18-bit reference angle width (2^17 = pi). Wider
// angle buses scale it up by a left shift. Angle widths below the
// reference are not supported.
package cordic_rot_pkg;

    localparam int unsigned REF_ANG_W = 18;

    // atan(2^-idx) expressed in units of pi / 2^17
    function automatic logic signed [31:0] step_angle(input int unsigned idx);
        logic signed [31:0] val;
        case (idx)
            0:       val = 32'sd32768;
            1:       val = 32'sd19344;
            2:       val = 32'sd10221;
            3:       val = 32'sd5188;
            4:       val = 32'sd2604;
            5:       val = 32'sd1303;
            6:       val = 32'sd652;
            7:       val = 32'sd326;
            8:       val = 32'sd163;
            9:       val = 32'sd81;
            10:      val = 32'sd41;
            11:      val = 32'sd20;
            12:      val = 32'sd10;
            13:      val = 32'sd5;
            14:      val = 32'sd3;
            15:      val = 32'sd1;
            default: val = 32'sd41722 >>> idx;
        endcase
        return val;
    endfunction

endpackage

// File: rtl/cordic_sat_addsub.sv
// cordic_sat_addsub
// Two's-complement add or subtract of W-bit operands with sign-holding
// saturation. The true result is formed one bit wider. If it does not
// fit in W bits, the output clamps to the largest magnitude carrying the
// true sign, so a crossing past full scale never flips the sign.
// Purely combinational.
module cordic_sat_addsub #(
    parameter int unsigned W = 18
) (
    input  logic signed [W-1:0] op_a,
    input  logic signed [W-1:0] op_b,
    input  logic                do_sub,
    output logic signed [W-1:0] result
);

    localparam logic signed [W-1:0] POS_MAX = {1'b0, {(W-1){1'b1}}};
    localparam logic signed [W-1:0] NEG_MAX = {1'b1, {(W-1){1'b0}}};

    logic signed [W:0] wide_a;
    logic signed [W:0] wide_b;
    logic signed [W:0] wide_sum;

    // one extra bit keeps the true result and its sign
    always_comb begin
        wide_a   = {op_a[W-1], op_a};
        wide_b   = {op_b[W-1], op_b};
        wide_sum = do_sub ? (wide_a - wide_b) : (wide_a + wide_b);
    end

    // clamp when the top two bits of the wide result disagree
    always_comb begin
        if (wide_sum[W] != wide_sum[W-1])
            result = wide_sum[W] ? NEG_MAX : POS_MAX;
        else
            result = wide_sum[W-1:0];
    end

endmodule

// File: rtl/cordic_micro_stage.sv
// cordic_micro_stage
// One circular-rotation micro-step. The sign of the incoming angle picks
// the direction that drives it toward zero. Cross terms come from fixed
// arithmetic shifts by SHIFT, so no variable shifter is built. The step
// angle is a constant parameter. All outputs are registered (one clock),
// and a synchronous active-low reset clears data and valid.
module cordic_micro_stage #(
    parameter int unsigned              DATA_W = 18,
    parameter int unsigned              ANG_W  = 18,
    parameter int unsigned              SHIFT  = 0,
    parameter logic signed [ANG_W-1:0]  STEP   = '0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_vld,
    input  logic signed [DATA_W-1:0] x_in,
    input  logic signed [DATA_W-1:0] y_in,
    input  logic signed [ANG_W-1:0]  z_in,
    output logic                     out_vld,
    output logic signed [DATA_W-1:0] x_out,
    output logic signed [DATA_W-1:0] y_out,
    output logic signed [ANG_W-1:0]  z_out
);

    localparam int unsigned DM = DATA_W - 1;

    logic                     dir_pos;
    logic signed [DATA_W-1:0] x_sh;
    logic signed [DATA_W-1:0] y_sh;
    logic signed [DATA_W-1:0] x_nxt;
    logic signed [DATA_W-1:0] y_nxt;
    logic signed [ANG_W-1:0]  z_nxt;

    // direction from angle sign, cross terms from wired shifts
    always_comb begin
        dir_pos = ~z_in[ANG_W-1];
        x_sh    = x_in >>> SHIFT;
        y_sh    = y_in >>> SHIFT;
    end

    cordic_sat_addsub #(.W(DATA_W)) u_x_add (
        .op_a(x_in), .op_b(y_sh), .do_sub(dir_pos), .result(x_nxt)
    );

    cordic_sat_addsub #(.W(DATA_W)) u_y_add (
        .op_a(y_in), .op_b(x_sh), .do_sub(~dir_pos), .result(y_nxt)
    );

    cordic_sat_addsub #(.W(ANG_W)) u_z_add (
        .op_a(z_in), .op_b(STEP), .do_sub(dir_pos), .result(z_nxt)
    );

    // stage register with synchronous clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld <= 1'b0;
            x_out   <= '0;
            y_out   <= '0;
            z_out   <= '0;
        end else begin
            out_vld <= in_vld;
            x_out   <= x_nxt;
            y_out   <= y_nxt;
            z_out   <= z_nxt;
        end
    end

    // R8
    no_wrap_x_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dir_pos && (x_in[DM] == y_sh[DM])) |=> (x_out[DM] == $past(x_in[DM])));

    // R8
    no_wrap_y_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_pos && (y_in[DM] == x_sh[DM])) |=> (y_out[DM] == $past(y_in[DM])));

    // R2
    vld_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> out_vld);

endmodule

// File: rtl/cordic_rot_pipe.sv
// cordic_rot_pipe
// Fully pipelined circular-rotation CORDIC: NUM_STAGES micro-stages, one
// register each, so latency equals NUM_STAGES clocks and one operand is
// accepted per clock. Assumes input angles in [-pi/2, +pi/2] (2^(ANG_W-1)
// = pi) and ANG_W of at least 18. The output length carries the stage gain;
// no compensation multiplier is present.
module cordic_rot_pipe #(
    parameter int unsigned NUM_STAGES = 16,
    parameter int unsigned DATA_W     = 18,
    parameter int unsigned ANG_W      = 18
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_vld,
    input  logic signed [DATA_W-1:0] in_x,
    input  logic signed [DATA_W-1:0] in_y,
    input  logic signed [ANG_W-1:0]  in_ang,
    output logic                     out_vld,
    output logic signed [DATA_W-1:0] out_x,
    output logic signed [DATA_W-1:0] out_y,
    output logic signed [ANG_W-1:0]  out_ang
);

    import cordic_rot_pkg::*;

    localparam int unsigned ANG_UP = ANG_W - REF_ANG_W;

    logic                     vld_c [0:NUM_STAGES];
    logic signed [DATA_W-1:0] x_c   [0:NUM_STAGES];
    logic signed [DATA_W-1:0] y_c   [0:NUM_STAGES];
    logic signed [ANG_W-1:0]  z_c   [0:NUM_STAGES];

    // chain head is the raw operand
    always_comb begin
        vld_c[0] = in_vld;
        x_c[0]   = in_x;
        y_c[0]   = in_y;
        z_c[0]   = in_ang;
    end

    for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
        localparam logic signed [ANG_W-1:0] STEP_ANG =
            ANG_W'(step_angle(g) <<< ANG_UP);

        cordic_micro_stage #(
            .DATA_W(DATA_W),
            .ANG_W (ANG_W),
            .SHIFT (g),
            .STEP  (STEP_ANG)
        ) u_stage (
            .clk    (clk),
            .rst_n  (rst_n),
            .in_vld (vld_c[g]),
            .x_in   (x_c[g]),
            .y_in   (y_c[g]),
            .z_in   (z_c[g]),
            .out_vld(vld_c[g+1]),
            .x_out  (x_c[g+1]),
            .y_out  (y_c[g+1]),
            .z_out  (z_c[g+1])
        );
    end

    // chain tail drives the ports
    always_comb begin
        out_vld = vld_c[NUM_STAGES];
        out_x   = x_c[NUM_STAGES];
        out_y   = y_c[NUM_STAGES];
        out_ang = z_c[NUM_STAGES];
    end

    // R1
    rst_clr_chk: assert property (@(posedge clk)
        !rst_n |=> !out_vld);

endmodule

// File: tb/cordic_rot_pipe_tb.sv
`timescale 1ns/1ps
module cordic_rot_pipe_tb;

    localparam int STAGES = 16;
    localparam int TOL    = 8;

    typedef struct {
        int    ex;
        int    ey;
        int    issue;
        int    mode;   // 0 sin/cos, 1 free vector, 2 saturation
        string tag;
    } exp_t;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_vld = 1'b0;
    logic signed [17:0] in_x = '0;
    logic signed [17:0] in_y = '0;
    logic signed [17:0] in_ang = '0;
    logic               out_vld;
    logic signed [17:0] out_x;
    logic signed [17:0] out_y;
    logic signed [17:0] out_ang;

    int   cyc = 0;
    int   errors = 0;
    int   checks = 0;
    bit   done = 1'b0;
    real  kgain;
    real  pi_c = 3.14159265358979;
    exp_t sb [$];

    cordic_rot_pipe u_dut (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_x(in_x), .in_y(in_y),
        .in_ang(in_ang), .out_vld(out_vld), .out_x(out_x), .out_y(out_y),
        .out_ang(out_ang)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic int rnd(input real r);
        return (r >= 0.0) ? $rtoi(r + 0.5) : -$rtoi(-r + 0.5);
    endfunction

    function automatic int iabs(input int v);
        return (v < 0) ? -v : v;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // driver: present one operand on a falling edge and queue its expectation
    task automatic send(input int x, input int y, input int ang, input int mode, input string tag);
        exp_t e;
        real th;
        real g;
        th = ang * pi_c / 131072.0;
        g  = 1.0 / kgain;
        @(negedge clk);
        in_vld = 1'b1;
        in_x   = 18'(x);
        in_y   = 18'(y);
        in_ang = 18'(ang);
        e.ex    = rnd(g * (x * $cos(th) - y * $sin(th)));
        e.ey    = rnd(g * (x * $sin(th) + y * $cos(th)));
        e.issue = cyc;
        e.mode  = mode;
        e.tag   = tag;
        sb.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_vld = 1'b0;
        end
    endtask

    // monitor: pop and compare each result as it leaves the pipeline
    always @(negedge clk) begin
        if (rst_n && out_vld && !done) begin
            if (sb.size() == 0) begin
                check(1'b0, "R9 unexpected result", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(cyc - e.issue == STAGES, {"R2 latency ", e.tag}, cyc - e.issue, STAGES);
                if (e.mode == 2) begin
                    check(int'(out_x) >= 90000, {"R8 no wrap x ", e.tag}, int'(out_x), 90000);
                end else begin
                    check(iabs(int'(out_x) - e.ex) <= TOL, {"x ", e.tag}, int'(out_x), e.ex);
                    check(iabs(int'(out_y) - e.ey) <= TOL, {"y ", e.tag}, int'(out_y), e.ey);
                    check(iabs(int'(out_ang)) <= TOL, {"R6 residual ", e.tag}, int'(out_ang), 0);
                end
            end
        end
    end

    initial begin
        int x0;
        int angs [10] = '{-65536, -50000, -32768, -1000, 0, 1, 12345, 32768, 50000, 65536};
        kgain = 1.0;
        for (int i = 0; i < STAGES; i++) kgain = kgain / $sqrt(1.0 + 2.0 ** (-2.0 * i));
        x0 = rnd(kgain * 65536.0);

        // R1: reset state
        repeat (3) @(negedge clk);
        check(out_vld == 1'b0, "R1 reset out_vld", int'(out_vld), 0);
        @(negedge clk);
        rst_n = 1'b1;
        idle(2);

        // R3 R4 R5: sine and cosine across the range, back to back (R9)
        for (int i = 0; i < 10; i++) begin
            if (angs[i] == 65536 || angs[i] == -65536)
                send(x0, 0, angs[i], 0, "R5 endpoint R3 R4");
            else
                send(x0, 0, angs[i], 0, "R3 R4 sincos");
        end
        idle(20);

        // R7: arbitrary start vectors, with gaps (R9)
        send(30000, 10000, 20000, 1, "R7 vec a");
        idle(3);
        send(-25000, 15000, -40000, 1, "R7 vec b");
        send(5000, -30000, 60000, 1, "R7 vec c");
        idle(1);
        send(-20000, -20000, 0, 1, "R7 vec d");
        idle(20);

        // R8: saturating adders keep the sign
        send(120000, 0, 0, 2, "sat");
        idle(20);

        // R1: reset with operands in flight discards them
        for (int i = 0; i < 5; i++) send(x0, 0, i * 1000, 0, "R1 flush");
        idle(3);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        sb.delete();
        rst_n = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            check(out_vld == 1'b0, "R1 flushed out_vld", int'(out_vld), 0);
        end

        // R9: long burst after reset
        for (int i = 0; i < 24; i++) send(x0, 0, -60000 + i * 5000, 0, "R9 burst R3 R4");
        idle(24);
        check(sb.size() == 0, "R9 all results returned", sb.size(), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule